// File: doc/BRIEF.md
# Fixed-Point Resize Unit with Selectable Rounding and Overflow Handling

This block converts a fixed-point word from one format to another. Each format is a total width plus a count of integer bits, and the remaining bits are the fraction. Signedness and all four widths are fixed at elaboration. The binary points of the two formats are lined up first. Low-order fraction bits that the output cannot hold are then removed under a quantization policy. High-order bits that the output cannot hold are then handled under an overflow policy. Where the output has more fraction bits, the extra low bits are filled with zeros. Where it has more integer bits, the value is sign- or zero-extended.

Both policies are chosen per cycle on two small mode inputs. One instance can therefore be swept over every input code and every mode combination. The conversion itself is combinational. The converted word and an out-of-range flag are captured in an output register, so a result appears one clock after its operands.

The default instance takes a signed 12-bit input with 5 integer bits (7 fraction bits). It produces a signed 8-bit output with 4 integer bits (4 fraction bits). Three fraction bits are dropped and one integer bit may be lost.

Top module: `fxc_resize`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `dout` and `ovf` become zero. Otherwise they take the conversion of the `din`, `qmode` and `omode` values present at that edge, so a result is visible one clock after its operands.
- R2: `qmode` = 0 truncates. The dropped fraction bits are discarded, which rounds toward minus infinity. Input code 401 (about 3.14) becomes output code 0x32 (3.125).
- R3: `qmode` = 1 rounds to the nearest output step. An exact half step goes toward plus infinity.
- R4: `qmode` = 2 rounds to the nearest output step. An exact half step goes toward zero.
- R5: `qmode` = 3 rounds to the nearest output step. An exact half step goes away from zero.
- R6: Quantization happens before the range check. A rounding carry that lifts the value above the output maximum is treated as an overflow by the selected `omode`.
- R7: `omode` = 0 wraps: `dout` holds the low output-width bits of the quantized value. `omode` = 3 behaves the same.
- R8: `omode` = 1 saturates. A value above the maximum gives the maximum code (0x7F for the default). A value below the minimum gives the minimum code (0x80).
- R9: `omode` = 2 saturates symmetrically. Values above the maximum give the maximum. Values below minus the maximum give minus the maximum (0x81), so the most negative code is never produced.
- R10: `ovf` is 1 exactly when the quantized value lies outside the output's full representable range, whatever `omode` is. A value equal to the most negative code is in range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | IN_W | Input fixed-point word |
| qmode | input | 2 | Quantization policy select |
| omode | input | 2 | Overflow policy select |
| dout | output | OUT_W | Converted word, registered |
| ovf | output | 1 | Quantized value did not fit the output range, registered |

## Verification
The only state is the output register. A wrong rounding or range decision therefore shows as a wrong `dout` or `ovf` on the very next clock, and only for the input codes and mode pair that exercise it. A bad half-step rule is visible only on exact ties. A missing carry check is visible only near the top of the range. For this reason the bench drives every input code under every mode pair and compares each cycle against an integer model. Directed ties, the rounding carry at the maximum and the most negative input under symmetric saturation are checked separately.

// File: rtl/fxc_pkg.sv
// Shared mode encodings for the fixed-point resize unit.
// Assumes: both mode inputs are two bits wide.
package fxc_pkg;

    // Quantization policies for dropped fraction bits
    typedef enum logic [1:0] {
        Q_TRUNC     = 2'd0,
        Q_NEAR_UP   = 2'd1,
        Q_NEAR_ZERO = 2'd2,
        Q_NEAR_AWAY = 2'd3
    } qmode_e;

    // Overflow policies for dropped integer bits
    typedef enum logic [1:0] {
        O_WRAP      = 2'd0,
        O_CLAMP     = 2'd1,
        O_CLAMP_SYM = 2'd2,
        O_WRAP_ALT  = 2'd3
    } omode_e;

endpackage

// File: rtl/fxc_quantize.sv
// Aligns the input binary point to the output fraction width and applies the
// quantization policy. Output carries one guard integer bit above the input
// integer width, so a rounding carry can never be lost here.
// Assumes: IN_W > IN_INT >= 1, OUT_FRAC >= 0.
module fxc_quantize
    import fxc_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int IN_INT   = 5,
    parameter int OUT_FRAC = 4,
    parameter bit SIGNED   = 1'b1,
    localparam int IN_FRAC = IN_W - IN_INT,
    localparam int QW      = IN_INT + 1 + OUT_FRAC
) (
    input  logic [IN_W-1:0] din,
    input  qmode_e          qmode,
    output logic [QW-1:0]   q_val
);

    logic ext_bit;
    assign ext_bit = SIGNED ? din[IN_W-1] : 1'b0;

    generate
        if (OUT_FRAC >= IN_FRAC) begin : g_widen
            localparam int PAD = OUT_FRAC - IN_FRAC;
            // Widening: extend by the guard bit and zero-fill new fraction bits
            if (PAD == 0) begin : g_nopad
                assign q_val = {ext_bit, din};
            end else begin : g_pad
                assign q_val = {ext_bit, din, {PAD{1'b0}}};
            end
        end else begin : g_narrow
            localparam int DROP = IN_FRAC - OUT_FRAC;
            localparam int BW   = IN_W - DROP;
            logic [BW-1:0]   kept;
            logic [DROP-1:0] rem;
            logic            half_bit;
            logic            rest_nz;
            logic            is_neg;
            logic            bump;

            assign kept     = din[IN_W-1:DROP];
            assign rem      = din[DROP-1:0];
            assign half_bit = rem[DROP-1];
            assign is_neg   = SIGNED && din[IN_W-1];

            if (DROP == 1) begin : g_one
                assign rest_nz = 1'b0;
            end else begin : g_many
                assign rest_nz = |rem[DROP-2:0];
            end

            // Decide whether the floor value is bumped up by one output step
            always_comb begin
                unique case (qmode)
                    Q_TRUNC:     bump = 1'b0;
                    Q_NEAR_UP:   bump = half_bit;
                    Q_NEAR_ZERO: bump = half_bit && (rest_nz || is_neg);
                    Q_NEAR_AWAY: bump = half_bit && (rest_nz || !is_neg);
                    default:     bump = 1'b0;
                endcase
            end

            // Floor value widened by the guard bit plus the rounding step
            assign q_val = {ext_bit, kept} + {{(QW-1){1'b0}}, bump};
        end
    endgenerate

endmodule

// File: rtl/fxc_limit.sv
// Checks the quantized value against the output range and applies the
// overflow policy. Input and output share the same fraction width, so the
// comparison is done on integers counted in output steps.
// Assumes: QW and OUT_W >= 2.
module fxc_limit
    import fxc_pkg::*;
#(
    parameter int QW     = 10,
    parameter int OUT_W  = 8,
    parameter bit SIGNED = 1'b1,
    localparam int CW    = ((QW > OUT_W) ? QW : OUT_W) + 2
) (
    input  logic [QW-1:0]    q_val,
    input  omode_e           omode,
    output logic [OUT_W-1:0] res,
    output logic             ovf
);

    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] MAXV = SIGNED ? ((ONE << (OUT_W-1)) - ONE)
                                            : ((ONE << OUT_W) - ONE);
    localparam logic [CW-1:0] MINV = SIGNED ? ~MAXV : {CW{1'b0}};
    localparam logic [CW-1:0] SYMV = SIGNED ? (~MAXV + ONE) : {CW{1'b0}};

    logic [CW-1:0] q_ext;
    logic          above;
    logic          below;
    logic          below_sym;

    // Extend the quantized value to the comparison width
    assign q_ext = {{(CW-QW){SIGNED ? q_val[QW-1] : 1'b0}}, q_val};

    // Range comparisons in two's complement at a width that cannot overflow
    always_comb begin
        above     = $signed(q_ext) > $signed(MAXV);
        below     = $signed(q_ext) < $signed(MINV);
        below_sym = $signed(q_ext) < $signed(SYMV);
    end

    assign ovf = above || below;

    // Choose the output code from the overflow policy
    always_comb begin
        unique case (omode)
            O_CLAMP: begin
                if (above)      res = MAXV[OUT_W-1:0];
                else if (below) res = MINV[OUT_W-1:0];
                else            res = q_ext[OUT_W-1:0];
            end
            O_CLAMP_SYM: begin
                if (above)          res = MAXV[OUT_W-1:0];
                else if (below_sym) res = SYMV[OUT_W-1:0];
                else                res = q_ext[OUT_W-1:0];
            end
            default: res = q_ext[OUT_W-1:0];
        endcase
    end

endmodule

// File: rtl/fxc_resize.sv
// Top of the fixed-point resize unit: quantizer, range limiter and one
// output register stage.
// Assumes: widths as in fxc_quantize; the mode inputs may change every cycle.
module fxc_resize
    import fxc_pkg::*;
#(
    parameter int IN_W    = 12,
    parameter int IN_INT  = 5,
    parameter int OUT_W   = 8,
    parameter int OUT_INT = 4,
    parameter bit SIGNED  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din,
    input  logic [1:0]       qmode,
    input  logic [1:0]       omode,
    output logic [OUT_W-1:0] dout,
    output logic             ovf
);

    localparam int OUT_FRAC = OUT_W - OUT_INT;
    localparam int QW       = IN_INT + 1 + OUT_FRAC;
    localparam logic [OUT_W-1:0] CODE_MAX = SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] CODE_MIN = SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};

    qmode_e           qm;
    omode_e           om;
    logic [QW-1:0]    q_w;
    logic [OUT_W-1:0] lim_res;
    logic             lim_ovf;

    assign qm = qmode_e'(qmode);
    assign om = omode_e'(omode);

    fxc_quantize #(
        .IN_W     (IN_W),
        .IN_INT   (IN_INT),
        .OUT_FRAC (OUT_FRAC),
        .SIGNED   (SIGNED)
    ) u_quant (
        .din   (din),
        .qmode (qm),
        .q_val (q_w)
    );

    fxc_limit #(
        .QW     (QW),
        .OUT_W  (OUT_W),
        .SIGNED (SIGNED)
    ) u_limit (
        .q_val (q_w),
        .omode (om),
        .res   (lim_res),
        .ovf   (lim_ovf)
    );

    // Output register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            ovf  <= 1'b0;
        end else begin
            dout <= lim_res;
            ovf  <= lim_ovf;
        end
    end

    // R8
    clamp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (om == O_CLAMP && lim_ovf) |-> (lim_res == CODE_MAX || lim_res == CODE_MIN));

    // R7
    wrap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((om == O_WRAP || om == O_WRAP_ALT) && lim_ovf) |-> (lim_res == q_w[OUT_W-1:0]));

    // R10
    fit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lim_ovf && om != O_CLAMP_SYM) |-> (lim_res == q_w[OUT_W-1:0]));

    // R9
    sym_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SIGNED && $past(rst_n) && $past(omode) == 2'd2) |-> (dout != CODE_MIN));

endmodule

// File: tb/fxc_resize_tb.sv
module fxc_resize_tb;

    localparam int IN_W    = 12;
    localparam int IN_INT  = 5;
    localparam int OUT_W   = 8;
    localparam int OUT_INT = 4;
    localparam int STEP    = 1 << ((IN_W - IN_INT) - (OUT_W - OUT_INT));
    localparam int OMAX    = (1 << (OUT_W - 1)) - 1;
    localparam int OMIN    = -(1 << (OUT_W - 1));

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IN_W-1:0]  din = '0;
    logic [1:0]       qmode = '0;
    logic [1:0]       omode = '0;
    logic [OUT_W-1:0] dout;
    logic             ovf;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fxc_resize #(
        .IN_W (IN_W), .IN_INT (IN_INT), .OUT_W (OUT_W), .OUT_INT (OUT_INT), .SIGNED (1'b1)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .din (din), .qmode (qmode), .omode (omode),
        .dout (dout), .ovf (ovf)
    );

    // Behavioural reference: integer arithmetic in output steps
    task automatic model(input int code, input int qm, input int om,
                         output int exp_code, output bit exp_ovf);
        int v, m, fl, q, lo;
        v  = (code >= (1 << (IN_W - 1))) ? code - (1 << IN_W) : code;
        m  = ((v % STEP) + STEP) % STEP;
        fl = (v - m) / STEP;
        case (qm)
            0: q = fl;
            1: q = fl + ((m >= STEP / 2) ? 1 : 0);
            2: q = fl + ((m > STEP / 2 || (m == STEP / 2 && v < 0)) ? 1 : 0);
            default: q = fl + ((m > STEP / 2 || (m == STEP / 2 && v >= 0)) ? 1 : 0);
        endcase
        exp_ovf = (q > OMAX) || (q < OMIN);
        lo = (om == 2) ? -OMAX : OMIN;
        if (om == 1 || om == 2) begin
            if (q > OMAX) q = OMAX;
            else if (q < lo) q = lo;
        end
        exp_code = ((q % (1 << OUT_W)) + (1 << OUT_W)) % (1 << OUT_W);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Drive operands at a falling edge, check the registered result one clock later
    task automatic apply(input int code, input int qm, input int om,
                         input string tag, input int exp_code, input int exp_ovf);
        din   = code[IN_W-1:0];
        qmode = qm[1:0];
        omode = om[1:0];
        @(negedge clk);
        check(tag, int'(dout), exp_code);
        check({tag, " ovf"}, int'(ovf), exp_ovf);
    endtask

    initial begin
        int ec;
        bit eo;
        string tg;
        din = 12'h5A5; qmode = 2'd1; omode = 2'd1;
        repeat (3) @(negedge clk);
        // R1: reset clears both outputs despite live operands
        check("R1 reset dout", int'(dout), 0);
        check("R1 reset ovf", int'(ovf), 0);
        rst_n = 1'b1;

        // R2: about 3.14 truncates to 3.125
        apply(401, 0, 0, "R2 trunc example", 8'h32, 0);
        // R3/R4/R5: exact half step, positive and negative
        apply(4, 1, 0, "R3 tie up pos", 1, 0);
        apply(4092, 1, 0, "R3 tie up neg", 0, 0);
        apply(4, 2, 0, "R4 tie zero pos", 0, 0);
        apply(4092, 2, 0, "R4 tie zero neg", 0, 0);
        apply(4, 3, 0, "R5 tie away pos", 1, 0);
        apply(4092, 3, 0, "R5 tie away neg", 8'hFF, 0);
        // R6: rounding carry past the maximum
        apply(1020, 1, 1, "R6 carry clamp", 8'h7F, 1);
        apply(1020, 1, 0, "R6 carry wrap", 8'h80, 1);
        apply(1020, 0, 1, "R6 no carry trunc", 8'h7F, 0);
        // R9/R10: most negative input under each overflow policy
        apply(3072, 0, 2, "R9 sym floor", 8'h81, 0);
        apply(3072, 0, 1, "R8 full floor", 8'h80, 0);
        apply(2048, 0, 1, "R8 below min", 8'h80, 1);
        apply(2048, 0, 3, "R7 alt wrap", 8'h00, 1);

        // Exhaustive sweep against the reference model
        for (int om = 0; om < 4; om++) begin
            for (int qm = 0; qm < 4; qm++) begin
                for (int c = 0; c < (1 << IN_W); c++) begin
                    model(c, qm, om, ec, eo);
                    if (eo) tg = (om == 1) ? "R8 sweep" : (om == 2) ? "R9 sweep" : "R7 sweep";
                    else tg = (qm == 0) ? "R2 sweep" : (qm == 1) ? "R3 sweep" :
                              (qm == 2) ? "R4 sweep" : "R5 sweep";
                    din = c[IN_W-1:0]; qmode = qm[1:0]; omode = om[1:0];
                    @(negedge clk);
                    check(tg, int'(dout), ec);
                    check("R10 sweep ovf", int'(ovf), int'(eo));
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule